// File: doc/BRIEF.md
# I2C Bus Busy Monitor

This block observes the two open-drain lines of a multi-master I2C bus and reports whether the bus is currently in use by any master. It samples raw SDA and SCL on a free-running functional clock, resynchronises both lines, and keeps a busy flag. It also keeps a sticky flag that records that a STOP condition ended a transfer. A host controller checks these flags before it starts its own transfer. This stops it from starting a START in the middle of another master's traffic.

Tracking starts when `enable` rises. On the first clock edge that samples `enable` high, the busy flag is seeded from the current synchronised line levels, and the valid output goes high. From then on, the block follows bus conditions. A START sets busy. Any cycle with SDA low while SCL is high also sets busy, as it would during an acknowledge bit. This lets a monitor that was enabled mid-transfer recover the correct busy state. A STOP clears busy and raises the bus-free flag. Single-cycle pulses mark each START and each STOP that the block detects.

Top module: `i2c_busy_monitor`

## Requirements
- R1: While `enable` is sampled low at a clock edge, `busBusy`, `busFree`, `busyValid`, `startPulse` and `stopPulse` are all 0 after that edge. Line activity during this time produces no pulses.
- R2: `busyValid` is 0 before the first clock edge that samples `enable` high, and it is 1 after that edge.
- R3: On that first enabled edge, `busBusy` is seeded from the synchronised lines: SDA=0/SCL=0 gives 0, SDA=1/SCL=0 gives 0, SDA=0/SCL=1 gives 1, SDA=1/SCL=1 gives 0. `busFree` is seeded to 0.
- R4: A falling SDA edge while SCL is high (START) sets `busBusy` and produces one `startPulse`. Both appear on the third clock edge after the raw line change.
- R5: SDA low while SCL is high sets `busBusy` even when no START edge was seen. No `startPulse` is produced in that case.
- R6: A rising SDA edge while SCL is high (STOP) clears `busBusy`, sets `busFree` and produces one `stopPulse`, on the third clock edge after the raw change.
- R7: `busFree` stays set until a one-cycle `freeClr` strobe arrives, and that strobe clears it.
- R8: When `freeClr` coincides with a STOP detection, `busFree` stays set.
- R9: SDA changes while SCL is low produce no pulse and leave `busBusy` unchanged.
- R10: Each pulse is one cycle wide. `startPulse` and `stopPulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low holds all outputs at 0 |
| sdaRaw | input | 1 | Unsynchronised SDA line level |
| sclRaw | input | 1 | Unsynchronised SCL line level |
| freeClr | input | 1 | One-cycle strobe that clears the bus-free flag |
| busBusy | output | 1 | Bus is in use |
| busFree | output | 1 | Sticky flag: a STOP was seen |
| busyValid | output | 1 | Busy flag is meaningful |
| startPulse | output | 1 | One-cycle mark of a START detection |
| stopPulse | output | 1 | One-cycle mark of a STOP detection |

## Verification
If the seed logic is wrong, `busBusy` is wrong on the very first enabled cycle. With lines idle high, that wrong value persists until the next bus condition arrives. A broken edge detector either misses or duplicates `startPulse`/`stopPulse`, and the event scoreboard catches this three cycles after the line change. A wrong priority between STOP and clear shows only in the exact cycle where they coincide, so the bench aims a clear strobe at that edge and then reads `busFree`.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

  // Conditions decoded from the synchronised lines
  typedef struct packed {
    logic start;    // SDA fell while SCL high
    logic stop;     // SDA rose while SCL high
    logic lowHigh;  // SDA low while SCL high (level)
  } lineEv_t;

  // Strobes from control to the datapath state registers
  typedef struct packed {
    logic clrAll;
    logic seed;
    logic setBusy;
    logic clrBusy;
    logic setFree;
    logic clrFree;
    logic markStart;
    logic markStop;
  } busCmd_t;

  typedef enum logic {ST_OFF = 1'b0, ST_TRACK = 1'b1} monState_t;

endpackage

// File: rtl/busmon_sync.sv
module busmon_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RESET_VAL}};
    else        pipe <= {pipe[LAST-1:0], din};
  end

  assign dout = pipe[LAST];

  initial begin
    stages_min_chk: assert (STAGES >= 2);
  end
endmodule

// File: rtl/busmon_datapath.sv
module busmon_datapath
  import busmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sdaRaw,
  input  logic    sclRaw,
  input  busCmd_t cmd,
  output lineEv_t ev,
  output logic    busBusy,
  output logic    busFree,
  output logic    startPulse,
  output logic    stopPulse
);
  localparam int NUM_LINES = 2;
  localparam int SDA_IDX   = 0;
  localparam int SCL_IDX   = 1;

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] syncLines;
  logic                 sdaPrev;

  assign rawLines = {sclRaw, sdaRaw};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sync
    busmon_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rawLines[i]),
      .dout (syncLines[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdaPrev <= 1'b1;
    else        sdaPrev <= syncLines[SDA_IDX];
  end

  always_comb begin
    ev.start   =  sdaPrev & ~syncLines[SDA_IDX] & syncLines[SCL_IDX];
    ev.stop    = ~sdaPrev &  syncLines[SDA_IDX] & syncLines[SCL_IDX];
    ev.lowHigh = ~syncLines[SDA_IDX] & syncLines[SCL_IDX];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busBusy    <= 1'b0;
      busFree    <= 1'b0;
      startPulse <= 1'b0;
      stopPulse  <= 1'b0;
    end else begin
      startPulse <= cmd.markStart;
      stopPulse  <= cmd.markStop;
      if (cmd.clrAll) begin
        busBusy <= 1'b0;
        busFree <= 1'b0;
      end else if (cmd.seed) begin
        busBusy <= ev.lowHigh;
        busFree <= 1'b0;
      end else begin
        if (cmd.clrBusy)      busBusy <= 1'b0;
        else if (cmd.setBusy) busBusy <= 1'b1;
        if (cmd.setFree)      busFree <= 1'b1;
        else if (cmd.clrFree) busFree <= 1'b0;
      end
    end
  end

  // R6
  stop_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.markStop |=> (!busBusy && busFree && stopPulse));

  // R5
  lowhigh_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.setBusy |=> busBusy);

  // R8
  free_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.setFree && cmd.clrFree == 1'b0) |=> busFree);

  // R10
  pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(startPulse && stopPulse));

  // R10
  start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);
endmodule

// File: rtl/busmon_ctrl.sv
module busmon_ctrl
  import busmon_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    freeClr,
  input  lineEv_t ev,
  output busCmd_t cmd,
  output logic    busyValid
);
  monState_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= enable ? ST_TRACK : ST_OFF;
  end

  assign busyValid = (state == ST_TRACK);

  always_comb begin
    cmd = '0;
    if (!enable) begin
      cmd.clrAll = 1'b1;
    end else if (state == ST_OFF) begin
      cmd.seed = 1'b1;
    end else begin
      if (ev.stop) begin
        cmd.clrBusy  = 1'b1;
        cmd.setFree  = 1'b1;
        cmd.markStop = 1'b1;
      end else if (ev.lowHigh) begin
        cmd.setBusy = 1'b1;
      end
      cmd.markStart = ev.start;
      cmd.clrFree   = freeClr & ~ev.stop;
    end
  end

  // R1
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busyValid && !cmd.markStart && !cmd.markStop));

  // R2
  valid_first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !busyValid) |=> busyValid);

  // R2
  valid_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busyValid) |-> $past(enable));

  // R4
  start_while_tracking_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.markStart |-> busyValid);
endmodule

// File: rtl/i2c_busy_monitor.sv
module i2c_busy_monitor
  import busmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sdaRaw,
  input  logic sclRaw,
  input  logic freeClr,
  output logic busBusy,
  output logic busFree,
  output logic busyValid,
  output logic startPulse,
  output logic stopPulse
);
  lineEv_t ev;
  busCmd_t cmd;

  busmon_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .freeClr  (freeClr),
    .ev       (ev),
    .cmd      (cmd),
    .busyValid(busyValid)
  );

  busmon_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdaRaw    (sdaRaw),
    .sclRaw    (sclRaw),
    .cmd       (cmd),
    .ev        (ev),
    .busBusy   (busBusy),
    .busFree   (busFree),
    .startPulse(startPulse),
    .stopPulse (stopPulse)
  );

  // R4
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |-> busBusy);
endmodule

// File: tb/i2c_busy_monitor_tb.sv
`timescale 1ns/1ps
module i2c_busy_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic sdaRaw = 1'b1;
  logic sclRaw = 1'b1;
  logic freeClr = 1'b0;
  logic busBusy, busFree, busyValid, startPulse, stopPulse;

  int compared = 0;
  int mismatched = 0;
  string evQ[$];

  always #4 clk = ~clk;

  i2c_busy_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sdaRaw(sdaRaw), .sclRaw(sclRaw),
    .freeClr(freeClr), .busBusy(busBusy), .busFree(busFree), .busyValid(busyValid),
    .startPulse(startPulse), .stopPulse(stopPulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkState(input bit b, input bit f, input bit v, input string req);
    chk(busBusy == b, req, "busBusy", busBusy, b);
    chk(busFree == f, req, "busFree", busFree, f);
    chk(busyValid == v, req, "busyValid", busyValid, v);
  endtask

  // Driver: set lines at a falling edge and let them pass the synchroniser
  task automatic drive(input bit sda, input bit scl);
    @(negedge clk);
    sdaRaw = sda;
    sclRaw = scl;
    repeat (4) @(negedge clk);
  endtask

  task automatic expectEv(input string name);
    evQ.push_back(name);
  endtask

  // Monitor: compare each pulse with the next expected event
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && (startPulse || stopPulse)) begin
        string act;
        string exp;
        act = startPulse ? (stopPulse ? "BOTH" : "START") : "STOP";
        exp = (evQ.size() > 0) ? evQ.pop_front() : "NONE";
        compared++;
        if (act != exp) begin
          mismatched++;
          $display("FAIL R4/R6/R10 event: actual=%s expected=%s", act, exp);
        end
      end
    end
  end

  task automatic seedCase(input bit sda, input bit scl, input bit expBusy);
    @(negedge clk);
    enable = 1'b0;
    drive(sda, scl);
    enable = 1'b1;
    #1;
    chk(busyValid == 1'b0, "R2", "valid before edge", busyValid, 0);
    @(posedge clk);
    #1;
    chk(busyValid == 1'b1, "R2", "valid after edge", busyValid, 1);
    chk(busBusy == expBusy, "R3", "seed busy", busBusy, expBusy);
    chk(busFree == 1'b0, "R3", "seed free", busFree, 0);
    @(negedge clk);
    enable = 1'b0;
    @(posedge clk);
    #1;
    checkState(0, 0, 0, "R1");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checkState(0, 0, 0, "R1");

    // R3 seed table
    seedCase(0, 0, 0);
    seedCase(1, 0, 0);
    seedCase(0, 1, 1);
    seedCase(1, 1, 0);

    // Idle bus, tracking enabled
    drive(1, 1);
    @(negedge clk);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    checkState(0, 0, 1, "R2");

    // R9: SCL low with SDA high, then back: no events
    drive(1, 0);
    drive(1, 1);
    checkState(0, 0, 1, "R9");

    // R4: START
    expectEv("START");
    drive(0, 1);
    checkState(1, 0, 1, "R4");

    // R9: data changes while SCL low
    drive(0, 0);
    drive(1, 0);
    drive(0, 0);
    drive(1, 0);
    checkState(1, 0, 1, "R9");

    // R4: repeated START while busy
    drive(1, 1);
    expectEv("START");
    drive(0, 1);
    checkState(1, 0, 1, "R4");

    // R6: STOP
    drive(0, 0);
    drive(0, 1);
    expectEv("STOP");
    drive(1, 1);
    checkState(0, 1, 1, "R6");

    // R7: sticky, then cleared by strobe
    repeat (20) @(negedge clk);
    checkState(0, 1, 1, "R7");
    freeClr = 1'b1;
    @(negedge clk);
    freeClr = 1'b0;
    checkState(0, 0, 1, "R7");

    // R5: SDA low then SCL high, no START edge
    drive(1, 0);
    drive(0, 0);
    checkState(0, 0, 1, "R5");
    drive(0, 1);
    checkState(1, 0, 1, "R5");

    // R8: clear aimed at the STOP detection edge
    expectEv("STOP");
    @(negedge clk);
    sdaRaw = 1'b1;
    @(negedge clk);
    @(negedge clk);
    freeClr = 1'b1;
    @(negedge clk);
    freeClr = 1'b0;
    repeat (2) @(negedge clk);
    checkState(0, 1, 1, "R8");

    // R1: disable while busy and free
    expectEv("START");
    drive(0, 1);
    checkState(1, 1, 1, "R4");
    enable = 1'b0;
    @(negedge clk);
    checkState(0, 0, 0, "R1");
    drive(1, 1);
    drive(0, 1);
    checkState(0, 0, 0, "R1");

    repeat (4) @(negedge clk);
    chk(evQ.size() == 0, "R10", "pending events", evQ.size(), 0);
    summary();
  end
endmodule